// File: doc/BRIEF.md
# Port-Addressed MDIO Management Engine

This block is a register-programmed MDIO master that lets software address Ethernet PHYs by switch port number rather than by bus and PHY address. Software loads two packed lookup tables, one giving each switch port a 5-bit PHY address and one giving it the MDIO bus it sits on, and a per-bus mode mask that selects clause 22 or clause 45 framing. It then launches single transactions through a command register. The engine looks up the bus and PHY address of the named port, generates MDC for that bus from the system clock, shifts the frame out on that bus's MDIO line, and for reads shifts the reply back in.

A read names its target by port number in the upper half of the data register and returns the 16-bit result in the lower half. A write names its target with a one-hot port mask and takes its value from the upper half of the data register. A clause 45 access uses a separate register holding the device address and the 16-bit register number, and is sent as an address frame followed by a read or write frame. Only one transaction runs at a time. A start bit doubles as busy flag, and a fail flag reports a rejected target.

Top module: `port_mdio_engine`

## Requirements
- R1: After reset the command register reads 0, every MDC output is low, every MDIO output enable is low and every MDIO output is high.
- R2: Writing the command register (word 0) with bit 0 set while idle and with a valid target starts a transaction. Bit 0 reads 1 from the next cycle for exactly 128×DIV cycles per frame (one frame in clause 22, two frames in clause 45) and then reads 0.
- R3: A command register write while bit 0 reads 1 has no effect. That includes a write in the last busy cycle. The stored fields stay unchanged and no extra frame is sent.
- R4: A clause 22 read to the port given in data register (word 1) bits [31:16] sends 32 ones, 01, 10, PHY address, register address (command bits [24:20]), then releases MDIO (enable low) for turnaround and data. The 16 bits sampled, MSB first, land in data bits [15:0], and bits [31:16] are kept.
- R5: A clause 22 write (command bit 2 = 1) goes to the single port set in the mask register (word 2). It sends 32 ones, 01, 01, PHY address, register address, 10, and data bits [31:16], with the enable high for all 64 bits.
- R6: On a clause 45 bus, an access sends an address frame (00, 00, PHY, device address from word 3 bits [20:16], 10, register number from word 3 bits [15:0]) followed by a frame with 00, opcode 11 for read or 01 for write, PHY, device address, 10, and data. The read frame releases MDIO from bit 46.
- R7: The PHY address of port p is read from table word 8+p/6, bits (p mod 6)×5 up to 4 above that. Its bus is read from table word 16+p/16, bits (p mod 16)×2 up to 1 above that. Table words read back as written.
- R8: Bit 16+b of the global register (word 4) puts bus b in clause 45 mode. A clear bit gives clause 22 framing on that bus.
- R9: A read naming a port of 28 or more, or a write whose mask does not have exactly one bit set among ports 0 to 27, never sets busy. It sets the fail flag (command bit 25) and sends no frame. The next accepted start clears the flag.
- R10: Only the addressed bus toggles MDC, with a period of 2×DIV clock cycles. MDIO output changes only together with an MDC falling edge.
- R11: The command fields in bits [24:3] and the type bit 1 read back as last written while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mdc | output | NBUS | Management clock per bus |
| mdio_out | output | NBUS | MDIO output value per bus |
| mdio_oe | output | NBUS | MDIO output enable per bus |
| mdio_in | input | NBUS | MDIO input value per bus |

## Verification
The critical overlap is a new command write arriving on the same clock edge where a running transaction retires and the busy bit drops. The bench provokes it by watching its own busy countdown and issuing a start-bit write timed to land on that final edge. It expects the write to be dropped: busy stays low afterwards, no new MDC activity appears, and the stored command fields keep their earlier values. The bench model also tracks busy and fail on every clock, so any shift of the retire edge by one cycle is reported.

// File: rtl/port_mdio_engine.sv
module port_mdio_engine #(
  parameter int NPORT = 28,
  parameter int NBUS  = 4,
  parameter int DIV   = 2,
  parameter int AW    = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic [NBUS-1:0] mdc,
  output logic [NBUS-1:0] mdio_out,
  output logic [NBUS-1:0] mdio_oe,
  input  logic [NBUS-1:0] mdio_in
);
  localparam int BW       = $clog2(NBUS);
  localparam int PW       = $clog2(NPORT);
  localparam int CW       = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int APW      = 32 / 5;
  localparam int BPW      = 32 / BW;
  localparam int PA_WORDS = (NPORT + APW - 1) / APW;
  localparam int BS_WORDS = (NPORT + BPW - 1) / BPW;
  localparam int A_CMD = 0, A_DATA = 1, A_MASK = 2, A_C45 = 3, A_GLB = 4;
  localparam int A_PA = 8, A_BS = 16;

  logic [4:0]  f_reg, f_park;
  logic [11:0] f_main;
  logic        f_dir, f_type, busy_q, fail_q;
  logic [15:0] d_hi, d_lo, c45_reg;
  logic [31:0] pmask;
  logic [4:0]  c45_dev;
  logic [NBUS-1:0] c45_en;
  logic [31:0] pa_tab [PA_WORDS];
  logic [31:0] bs_tab [BS_WORDS];

  logic [BW-1:0] run_bus;
  logic [4:0]    run_phy, run_dev;
  logic [15:0]   run_creg, run_wval, rsh;
  logic          run_rd, run_c45, frame_idx, half, mdc_q;
  logic [5:0]    bitn;
  logic [CW-1:0] cnt;

  wire cmd_wr    = reg_wr && (reg_addr == AW'(A_CMD));
  wire start_req = cmd_wr && reg_wdata[0] && !busy_q;
  wire new_rd    = !reg_wdata[2];

  logic [PW-1:0] enc, tgt;
  logic          tgt_ok;
  logic [4:0]    lk_phy;
  logic [BW-1:0] lk_bus;

  always_comb begin
    enc = '0;
    for (int p = 0; p < NPORT; p++)
      if (pmask[p]) enc = PW'(p);
  end

  wire mask_ok = ($countones(pmask) == 1) && (|pmask[NPORT-1:0]);
  wire port_ok = d_hi < 16'(NPORT);

  assign tgt    = new_rd ? d_hi[PW-1:0] : enc;
  assign tgt_ok = new_rd ? port_ok : mask_ok;

  always_comb begin
    lk_phy = '0;
    lk_bus = '0;
    for (int p = 0; p < NPORT; p++)
      if (tgt == PW'(p)) begin
        lk_phy = pa_tab[p / APW][(p % APW) * 5 +: 5];
        lk_bus = bs_tab[p / BPW][(p % BPW) * BW +: BW];
      end
  end

  wire last_frame = !run_c45 || frame_idx;
  wire released   = run_rd && last_frame && (bitn >= 6'd46);
  wire sample_now = run_rd && last_frame && (bitn >= 6'd48);
  wire [1:0]  ph_op  = run_rd ? 2'b10 : 2'b01;
  wire [15:0] ph_dat = run_rd ? 16'hFFFF : run_wval;

  logic [63:0] frm;
  always_comb begin
    if (!run_c45)
      frm = {32'hFFFF_FFFF, 2'b01, ph_op, run_phy, run_dev, 2'b10, ph_dat};
    else if (!frame_idx)
      frm = {32'hFFFF_FFFF, 4'b0000, run_phy, run_dev, 2'b10, run_creg};
    else
      frm = {32'hFFFF_FFFF, 2'b00, (run_rd ? 2'b11 : 2'b01), run_phy, run_dev, 2'b10, ph_dat};
  end
  wire out_bit = frm[6'd63 - bitn];

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    wire act = busy_q && (run_bus == BW'(b));
    assign mdc[b]      = act && mdc_q;
    assign mdio_oe[b]  = act && !released;
    assign mdio_out[b] = act ? out_bit : 1'b1;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(A_CMD))
      reg_rdata = {6'b0, fail_q, f_reg, f_park, f_main, f_dir, f_type, busy_q};
    if (reg_addr == AW'(A_DATA)) reg_rdata = {d_hi, d_lo};
    if (reg_addr == AW'(A_MASK)) reg_rdata = pmask;
    if (reg_addr == AW'(A_C45))  reg_rdata = {11'b0, c45_dev, c45_reg};
    if (reg_addr == AW'(A_GLB))  reg_rdata[16 +: NBUS] = c45_en;
    for (int w = 0; w < PA_WORDS; w++)
      if (reg_addr == AW'(A_PA + w)) reg_rdata = pa_tab[w];
    for (int w = 0; w < BS_WORDS; w++)
      if (reg_addr == AW'(A_BS + w)) reg_rdata = bs_tab[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_reg <= '0; f_park <= '0; f_main <= '0; f_dir <= 1'b0; f_type <= 1'b0;
      busy_q <= 1'b0; fail_q <= 1'b0;
      d_hi <= '0; d_lo <= '0; pmask <= '0; c45_dev <= '0; c45_reg <= '0; c45_en <= '0;
      for (int w = 0; w < PA_WORDS; w++) pa_tab[w] <= '0;
      for (int w = 0; w < BS_WORDS; w++) bs_tab[w] <= '0;
      run_bus <= '0; run_phy <= '0; run_dev <= '0; run_creg <= '0; run_wval <= '0;
      rsh <= '0; run_rd <= 1'b0; run_c45 <= 1'b0; frame_idx <= 1'b0;
      half <= 1'b0; mdc_q <= 1'b0; bitn <= '0; cnt <= '0;
    end else begin
      if (reg_wr) begin
        if (reg_addr == AW'(A_DATA)) begin d_hi <= reg_wdata[31:16]; d_lo <= reg_wdata[15:0]; end
        if (reg_addr == AW'(A_MASK)) pmask <= reg_wdata;
        if (reg_addr == AW'(A_C45)) begin c45_dev <= reg_wdata[20:16]; c45_reg <= reg_wdata[15:0]; end
        if (reg_addr == AW'(A_GLB)) c45_en <= reg_wdata[16 +: NBUS];
        for (int w = 0; w < PA_WORDS; w++)
          if (reg_addr == AW'(A_PA + w)) pa_tab[w] <= reg_wdata;
        for (int w = 0; w < BS_WORDS; w++)
          if (reg_addr == AW'(A_BS + w)) bs_tab[w] <= reg_wdata;
      end
      if (cmd_wr && !busy_q) begin
        f_reg  <= reg_wdata[24:20];
        f_park <= reg_wdata[19:15];
        f_main <= reg_wdata[14:3];
        f_dir  <= reg_wdata[2];
        f_type <= reg_wdata[1];
      end
      if (start_req && tgt_ok) begin
        busy_q    <= 1'b1;
        fail_q    <= 1'b0;
        run_bus   <= lk_bus;
        run_phy   <= lk_phy;
        run_rd    <= new_rd;
        run_c45   <= c45_en[lk_bus];
        run_dev   <= c45_en[lk_bus] ? c45_dev : reg_wdata[24:20];
        run_creg  <= c45_reg;
        run_wval  <= d_hi;
        frame_idx <= 1'b0;
        bitn      <= '0;
        half      <= 1'b0;
        cnt       <= '0;
        mdc_q     <= 1'b0;
      end else if (start_req) begin
        fail_q <= 1'b1;
      end else if (busy_q) begin
        if (cnt == CW'(DIV - 1)) begin
          cnt <= '0;
          if (!half) begin
            half  <= 1'b1;
            mdc_q <= 1'b1;
            if (sample_now) rsh <= {rsh[14:0], mdio_in[run_bus]};
          end else begin
            half  <= 1'b0;
            mdc_q <= 1'b0;
            if (bitn == 6'd63) begin
              bitn <= '0;
              if (last_frame) begin
                busy_q <= 1'b0;
                if (run_rd) d_lo <= rsh;
              end else begin
                frame_idx <= 1'b1;
              end
            end else begin
              bitn <= bitn + 6'd1;
            end
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/port_mdio_engine_chk.sv
module port_mdio_engine_chk #(
  parameter int NBUS = 4,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            fail,
  input logic            reg_wr,
  input logic [AW-1:0]   reg_addr,
  input logic [23:0]     fields,
  input logic [NBUS-1:0] mdc,
  input logic [NBUS-1:0] mdio_oe,
  input logic [NBUS-1:0] mdio_out
);
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mdc == '0 && mdio_oe == '0)); // R1

  AST_SINGLE_MDC: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mdc)); // R10

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mdio_out != $past(mdio_out))) |-> ((|$past(mdc)) && !(|mdc))); // R10

  AST_HOLD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == '0) |=> $stable(fields)); // R3

  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr == '0)); // R2

  AST_FAIL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !busy); // R9
endmodule

bind port_mdio_engine port_mdio_engine_chk #(.NBUS(NBUS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .fail(fail_q),
  .reg_wr(reg_wr), .reg_addr(reg_addr),
  .fields({f_reg, f_park, f_main, f_dir, f_type}),
  .mdc(mdc), .mdio_oe(mdio_oe), .mdio_out(mdio_out)
);

// File: tb/port_mdio_engine_test.sv
module port_mdio_engine_test;
  localparam int DIV = 2;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [3:0]  mdc, mdio_out, mdio_oe, mdio_in = 4'hF;

  port_mdio_engine #(.NPORT(28), .NBUS(4), .DIV(DIV), .AW(5)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in));

  always #5 clk = ~clk;

  int errs = 0, nchk = 0, nlen = 0, mcnt = 0;
  logic mfail = 0, done = 0;
  logic [15:0] resp16 = 16'h0;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // reference model of busy and fail
  always @(posedge clk) begin
    if (!rst_n) begin mcnt <= 0; mfail <= 0; end
    else if (reg_wr && reg_addr == 0 && reg_wdata[0] && mcnt == 0) begin
      mcnt <= nlen; mfail <= (nlen == 0);
    end else if (mcnt > 0) mcnt <= mcnt - 1;
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && reg_addr == 0 && !done) begin
      chk("R2 busy", {63'b0, reg_rdata[0]}, {63'b0, (mcnt > 0)});
      chk("R9 fail", {63'b0, reg_rdata[25]}, {63'b0, mfail});
    end
  end

  // bench PHY: captures frames and drives read data
  logic [63:0] sh_o = 0, sh_e = 0;
  int kk = 0, cyc = 0, rise_a = 0, rise_b = 0;
  logic [3:0] pmdc = 0;
  logic [63:0] fq_o[$], fq_e[$];
  int fq_b[$];
  always @(negedge clk) begin
    cyc++;
    if ($countones(mdc) > 1) chk("R10 one mdc", {60'b0, mdc}, 64'h1);
    for (int b = 0; b < 4; b++)
      if (mdc[b] && !pmdc[b]) begin
        rise_a = rise_b; rise_b = cyc;
        sh_o = {sh_o[62:0], mdio_out[b]};
        sh_e = {sh_e[62:0], mdio_oe[b]};
        kk++;
        if (kk == 64) begin
          fq_o.push_back(sh_o); fq_e.push_back(sh_e); fq_b.push_back(b); kk = 0;
        end
        mdio_in = 4'hF;
        mdio_in[b] = (kk >= 48) ? resp16[63 - kk] : 1'b1;
      end
    pmdc = mdc;
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    reg_addr = a; #1 v = reg_rdata; reg_addr = 0;
  endtask

  task automatic wait_idle();
    while (mcnt != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] mk_cmd(input logic [4:0] r, input logic [4:0] pk,
                                         input logic [11:0] mn, input logic w, input logic t);
    return {7'b0, r, pk, mn, w, t, 1'b1};
  endfunction

  function automatic logic [63:0] exp_frame(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] phy, input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, phy, r, 2'b10, d};
  endfunction

  localparam logic [63:0] RD_MASK = {{46{1'b1}}, 18'b0};

  task automatic chk_frame(input string req, input int bus, input logic [63:0] exp,
                           input logic is_rd);
    logic [63:0] o, e, m;
    m = is_rd ? RD_MASK : '1;
    if (fq_o.size() == 0) begin chk(req, 64'hDEAD, 64'h1); return; end
    o = fq_o.pop_front(); e = fq_e.pop_front();
    chk(req, 64'(fq_b.pop_front()), 64'(bus));
    chk(req, o & m, exp & m);
    chk(req, e, m);
  endtask

  int pa_addr[28], pa_bus[28];
  logic [31:0] v, pw[5], bw[2];
  logic [31:0] keep_cmd;

  initial begin
    for (int p = 0; p < 28; p++) begin pa_addr[p] = 0; pa_bus[p] = 0; end
    pa_addr[5] = 5'h11; pa_bus[5] = 1;
    pa_addr[6] = 5'h03; pa_bus[6] = 0;
    pa_addr[17] = 5'h0A; pa_bus[17] = 2;
    pa_addr[27] = 5'h1E; pa_bus[27] = 3;
    for (int w = 0; w < 5; w++) pw[w] = 0;
    for (int w = 0; w < 2; w++) bw[w] = 0;
    for (int p = 0; p < 28; p++) begin
      pw[p / 6] |= 32'(pa_addr[p]) << ((p % 6) * 5);
      bw[p / 16] |= 32'(pa_bus[p]) << ((p % 16) * 2);
    end

    repeat (3) @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 cmd", 64'(v), 0);
    chk("R1 pins", {52'b0, mdc, mdio_oe, mdio_out}, {52'b0, 4'h0, 4'h0, 4'hF});
    rst_n = 1;
    @(negedge clk);

    for (int w = 0; w < 5; w++) wr(5'(8 + w), pw[w]);
    for (int w = 0; w < 2; w++) wr(5'(16 + w), bw[w]);
    wr(4, 32'h0008_0000);
    rd(8 + 5 / 6, v); chk("R7 phy table", 64'(v), 64'(pw[0]));
    rd(16 + 27 / 16, v); chk("R7 bus table", 64'(v), 64'(bw[1]));

    // R4 clause 22 read, port 5 -> bus 1 phy 0x11
    wr(1, {16'd5, 16'h0});
    resp16 = 16'hBEEF; nlen = 128 * DIV;
    wr(0, mk_cmd(5'h02, 5'h1F, 12'hABC, 0, 0));
    wait_idle();
    chk_frame("R4 c22 read frame", 1, exp_frame(2'b01, 2'b10, 5'h11, 5'h02, 16'h0), 1);
    rd(1, v); chk("R4 read data", 64'(v), {32'b0, 16'd5, 16'hBEEF});
    chk("R10 mdc period", 64'(rise_b - rise_a), 64'(2 * DIV));
    rd(0, v); chk("R11 fields", 64'(v), {32'b0, mk_cmd(5'h02, 5'h1F, 12'hABC, 0, 0) & 32'hFFFF_FFFE});

    // R5 write port 6 -> bus 0 phy 3, with ignored command while busy (R3)
    wr(2, 32'h0000_0040);
    wr(1, {16'h1234, 16'h0});
    nlen = 128 * DIV;
    wr(0, mk_cmd(5'h1F, 5'h00, 12'h001, 1, 0));
    keep_cmd = mk_cmd(5'h1F, 5'h00, 12'h001, 1, 0) & 32'hFFFF_FFFE;
    repeat (10) @(negedge clk);
    wr(0, mk_cmd(5'h07, 5'h07, 12'h777, 0, 1));
    wait_idle();
    chk_frame("R5 c22 write frame", 0, exp_frame(2'b01, 2'b01, 5'h03, 5'h1F, 16'h1234), 0);
    chk("R3 no extra frame", 64'(fq_o.size()), 0);
    rd(0, v); chk("R3 fields kept", 64'(v), 64'(keep_cmd));

    // R6 clause 45 read on bus 3, port 27
    wr(3, {11'b0, 5'd7, 16'hA5A5});
    wr(1, {16'd27, 16'h0});
    resp16 = 16'h0F0F; nlen = 256 * DIV;
    wr(0, mk_cmd(5'h00, 5'h00, 12'h000, 0, 1));
    wait_idle();
    chk_frame("R6 c45 addr frame", 3, exp_frame(2'b00, 2'b00, 5'h1E, 5'd7, 16'hA5A5), 0);
    chk_frame("R6 c45 read frame", 3, exp_frame(2'b00, 2'b11, 5'h1E, 5'd7, 16'h0), 1);
    rd(1, v); chk("R6 c45 read data", 64'(v), {32'b0, 16'd27, 16'h0F0F});

    // R6 clause 45 write
    wr(2, 32'h0800_0000);
    wr(1, {16'hCAFE, 16'h0});
    nlen = 256 * DIV;
    wr(0, mk_cmd(5'h00, 5'h00, 12'h000, 1, 1));
    wait_idle();
    chk_frame("R6 c45 addr frame w", 3, exp_frame(2'b00, 2'b00, 5'h1E, 5'd7, 16'hA5A5), 0);
    chk_frame("R6 c45 write frame", 3, exp_frame(2'b00, 2'b01, 5'h1E, 5'd7, 16'hCAFE), 0);

    // R8 bus 3 back to clause 22; also port 17 on bus 2
    wr(4, 32'h0);
    wr(1, {16'd27, 16'h0});
    resp16 = 16'h8001; nlen = 128 * DIV;
    wr(0, mk_cmd(5'h09, 5'h00, 12'h000, 0, 0));
    wait_idle();
    chk_frame("R8 c22 on bus 3", 3, exp_frame(2'b01, 2'b10, 5'h1E, 5'h09, 16'h0), 1);
    rd(1, v); chk("R8 read data", 64'(v), {32'b0, 16'd27, 16'h8001});
    wr(1, {16'd17, 16'h0});
    resp16 = 16'h5A5A; nlen = 128 * DIV;
    wr(0, mk_cmd(5'h01, 5'h00, 12'h000, 0, 0));
    wait_idle();
    chk_frame("R7 port 17 lookup", 2, exp_frame(2'b01, 2'b10, 5'h0A, 5'h01, 16'h0), 1);

    // R9 rejected targets
    wr(1, {16'd28, 16'h0}); nlen = 0;
    wr(0, mk_cmd(5'h01, 5'h00, 12'h000, 0, 0));
    repeat (3) @(negedge clk);
    rd(0, v); chk("R9 port 28 fail", {62'b0, v[25], v[0]}, 64'h2);
    wr(2, 32'h0); wr(0, mk_cmd(5'h01, 5'h00, 12'h000, 1, 0));
    repeat (3) @(negedge clk);
    rd(0, v); chk("R9 zero mask", {62'b0, v[25], v[0]}, 64'h2);
    wr(2, 32'h0000_0060); wr(0, mk_cmd(5'h01, 5'h00, 12'h000, 1, 0));
    repeat (3) @(negedge clk);
    rd(0, v); chk("R9 two-bit mask", {62'b0, v[25], v[0]}, 64'h2);
    wr(2, 32'h1000_0000); wr(0, mk_cmd(5'h01, 5'h00, 12'h000, 1, 0));
    repeat (3) @(negedge clk);
    rd(0, v); chk("R9 mask beyond ports", {62'b0, v[25], v[0]}, 64'h2);
    chk("R9 no frames", 64'(fq_o.size() + kk), 0);
    wr(2, 32'h0000_0020); wr(1, {16'h00FF, 16'h0}); nlen = 128 * DIV;
    wr(0, mk_cmd(5'h04, 5'h00, 12'h000, 1, 0));
    rd(0, v); chk("R9 fail cleared", {62'b0, v[25], v[0]}, 64'h1);
    wait_idle();
    chk_frame("R5 port 5 write", 1, exp_frame(2'b01, 2'b01, 5'h11, 5'h04, 16'h00FF), 0);

    // R3 command landing on the retiring edge
    wr(1, {16'd6, 16'h0}); resp16 = 16'h1111; nlen = 128 * DIV;
    wr(0, mk_cmd(5'h03, 5'h02, 12'h010, 0, 0));
    keep_cmd = mk_cmd(5'h03, 5'h02, 12'h010, 0, 0) & 32'hFFFF_FFFE;
    while (mcnt != 1) @(negedge clk);
    wr(0, mk_cmd(5'h1C, 5'h1C, 12'hFFF, 0, 1));
    repeat (20) @(negedge clk);
    chk("R3 last-cycle write dropped", {60'b0, mdc}, 0);
    rd(0, v); chk("R3 fields after retire", 64'(v), 64'(keep_cmd));
    chk_frame("R4 port 6 read", 0, exp_frame(2'b01, 2'b10, 5'h03, 5'h03, 16'h0), 1);
    chk("R3 single frame", 64'(fq_o.size() + kk), 0);
    rd(1, v); chk("R4 data port 6", 64'(v), {32'b0, 16'd6, 16'h1111});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    #2_000_000;
    errs++; nchk++; done = 1;
    $display("FAIL R2 watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule